// File: doc/BRIEF.md
# DRAM Row Boundary Decoder

This block maps a physical address onto one of the DRAM rows (chip-select groups) of a memory controller. Software programs one boundary byte per row. Each byte holds the running total of memory in that row and in every row below it, counted in 8 MB units. An address falls in the lowest row whose boundary, scaled to bytes, is greater than the address. A row whose total equals the total of the row beneath it holds no memory, so it is never picked.

A control byte can carve one of two hard-wired windows out of the DRAM map: either the 128 KB window at 512 KB–640 KB, or the 1 MB window at 15 MB–16 MB. An address inside the enabled window reports `in_hole` and does not hit any row. An address at or beyond the highest boundary also hits no row. The decoder produces a one-hot row select, a binary row index and a hit flag. In the default build these outputs are registered, so they appear one cycle after the address is applied.

Top module: `dram_row_decoder`

## Requirements
- R1: After reset every boundary byte and the hole field are zero, and no address produces a hit until the boundaries are programmed; a reset applied at any time clears the outputs at once.
- R2: A configuration write with `cfg_sel` 0..7 loads boundary byte `cfg_sel`, and `cfg_sel` = 8 loads the hole-control byte. A write takes effect for addresses decoded from the next clock onward. Writes with `cfg_sel` 9..15 change nothing.
- R3: An address hits row i, where i is the lowest row for which floor(address / 8 MB) < boundary[i].
- R4: A row whose boundary equals the boundary of the row below it (or equals zero, for row 0) is never selected; the address goes to the next non-empty row above it.
- R5: When no boundary exceeds floor(address / 8 MB), `hit` is 0, `row_select` is all zero and `row_index` is 0.
- R6: Hole code 01 in control bits [7:6] makes addresses 0x80000 through 0x9FFFF report `in_hole`=1 with `hit`=0 and `row_select`=0. The addresses just outside that window decode normally.
- R7: Hole code 10 in control bits [7:6] makes addresses 0xF00000 through 0xFFFFFF report `in_hole`=1 with `hit`=0. The addresses just outside that window decode normally.
- R8: Hole codes 00 and 11 carve out no window. Control bits [5:0] have no effect on decoding.
- R9: With the default output register, `hit`, `in_hole`, `row_select` and `row_index` reflect the address present at the previous rising clock edge. While `hit` is 1, `row_index` is the binary position of the set bit of `row_select`.
- R10: While `hit` is 1, exactly one bit of `row_select` is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Register select: 0..7 boundary bytes, 8 hole control |
| cfg_wdata | input | 8 | Configuration write data |
| addr | input | 32 | Physical address to decode |
| row_select | output | 8 | One-hot row select, zero when there is no hit |
| row_index | output | 3 | Binary index of the selected row, zero when there is no hit |
| hit | output | 1 | Address lies in a populated row and outside any enabled hole |
| in_hole | output | 1 | Address lies inside the enabled hole window |

## Verification
The main table programs a boundary set with three empty rows, one of them at the top just below the last populated row, and enables the low hole with junk in the reserved bits. It sweeps the first and last byte of every populated row, both edges of the hole, and addresses past the top boundary. An off-by-one in the compare shows up at a row edge. A wrong priority shows up as a selected empty row. A loose hole window shows up at the edges of the hole. Directed passes then switch the hole field through the high-window, reserved and no-hole codes at the same edge addresses. They also probe the one-cycle output latency, ignored register selects, a boundary rewrite, and decoding before programming and after a mid-run reset.

// File: rtl/rbd_pkg.sv
package rbd_pkg;

   // hole-control field encoding (control byte bits [7:6])
   typedef enum logic [1:0] {
      HOLE_NONE = 2'b00,
      HOLE_LOW  = 2'b01,
      HOLE_HIGH = 2'b10,
      HOLE_RSVD = 2'b11
   } hole_sel_e;

   localparam int HOLE_FIELD_MSB = 7;
   localparam int HOLE_FIELD_LSB = 6;

   // fixed window limits, base inclusive, limit exclusive
   localparam logic [31:0] LOW_HOLE_BASE   = 32'h0008_0000;
   localparam logic [31:0] LOW_HOLE_LIMIT  = 32'h000A_0000;
   localparam logic [31:0] HIGH_HOLE_BASE  = 32'h00F0_0000;
   localparam logic [31:0] HIGH_HOLE_LIMIT = 32'h0100_0000;

endpackage

// File: rtl/rbd_cfg_regs.sv
module rbd_cfg_regs #(
   parameter int ROWS  = 8,
   parameter int BND_W = 8,
   parameter int SEL_W = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [SEL_W-1:0]           sel,
   input  logic [BND_W-1:0]           wdata,
   output logic [ROWS-1:0][BND_W-1:0] bnd_o,
   output rbd_pkg::hole_sel_e         hole_o
);
   import rbd_pkg::*;

   localparam logic [SEL_W-1:0] HOLE_SLOT = SEL_W'(ROWS);

   for (genvar g = 0; g < ROWS; g++) begin : g_bnd
      localparam logic [SEL_W-1:0] SLOT = SEL_W'(g);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bnd_o[g] <= '0;
         else if (we && sel == SLOT)
            bnd_o[g] <= wdata;
      end

      assert_bnd_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(we) && $past(sel) == SLOT) |-> bnd_o[g] == $past(wdata))
         else $error("boundary %0d not loaded", g);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hole_o <= HOLE_NONE;
      else if (we && sel == HOLE_SLOT)
         hole_o <= hole_sel_e'(wdata[HOLE_FIELD_MSB:HOLE_FIELD_LSB]);
   end

   assert_ignore_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(we) && $past(sel) > HOLE_SLOT) |-> ($stable(bnd_o) && $stable(hole_o)))
      else $error("out-of-range select changed state");

endmodule

// File: rtl/rbd_row_match.sv
module rbd_row_match #(
   parameter int ROWS  = 8,
   parameter int BND_W = 8,
   parameter int UW    = 9,
   parameter int IDX_W = 3
) (
   input  logic [ROWS-1:0][BND_W-1:0] bnd,
   input  logic [UW-1:0]              units,
   output logic [ROWS-1:0]            sel,
   output logic [IDX_W-1:0]           idx,
   output logic                       any
);
   localparam int CW = (UW > BND_W) ? UW : BND_W;

   logic [ROWS-1:0] below;

   // one comparator per row: address lies under this row's running total
   for (genvar g = 0; g < ROWS; g++) begin : g_cmp
      assign below[g] = CW'(units) < CW'(bnd[g]);
   end

   // lowest matching row wins, which also skips empty rows
   always_comb begin
      sel = '0;
      idx = '0;
      for (int i = ROWS - 1; i >= 0; i--) begin
         if (below[i]) begin
            sel = '0;
            sel[i] = 1'b1;
            idx = IDX_W'(i);
         end
      end
   end

   assign any = |below;

endmodule

// File: rtl/rbd_hole_check.sv
module rbd_hole_check #(
   parameter int ADDR_W = 32
) (
   input  rbd_pkg::hole_sel_e  mode,
   input  logic [ADDR_W-1:0]   addr,
   output logic                in_hole
);
   import rbd_pkg::*;

   localparam logic [ADDR_W-1:0] LO_B = ADDR_W'(LOW_HOLE_BASE);
   localparam logic [ADDR_W-1:0] LO_L = ADDR_W'(LOW_HOLE_LIMIT);
   localparam logic [ADDR_W-1:0] HI_B = ADDR_W'(HIGH_HOLE_BASE);
   localparam logic [ADDR_W-1:0] HI_L = ADDR_W'(HIGH_HOLE_LIMIT);

   logic in_low, in_high;

   assign in_low  = (addr >= LO_B) && (addr < LO_L);
   assign in_high = (addr >= HI_B) && (addr < HI_L);

   always_comb begin
      unique case (mode)
         HOLE_LOW:  in_hole = in_low;
         HOLE_HIGH: in_hole = in_high;
         default:   in_hole = 1'b0;   // none, and the reserved code
      endcase
   end

endmodule

// File: rtl/dram_row_decoder.sv
module dram_row_decoder #(
   parameter int ADDR_W    = 32,
   parameter int ROWS      = 8,
   parameter int BND_W     = 8,
   parameter int UNIT_LOG2 = 23,
   parameter bit OUT_REG   = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cfg_we,
   input  logic [$clog2(ROWS+1)-1:0]   cfg_sel,
   input  logic [BND_W-1:0]            cfg_wdata,
   input  logic [ADDR_W-1:0]           addr,
   output logic [ROWS-1:0]             row_select,
   output logic [$clog2(ROWS)-1:0]     row_index,
   output logic                        hit,
   output logic                        in_hole
);
   import rbd_pkg::*;

   localparam int SEL_W = $clog2(ROWS + 1);
   localparam int IDX_W = $clog2(ROWS);
   localparam int UW    = ADDR_W - UNIT_LOG2;

   // elaboration-time parameter checks
   if (ROWS < 2 || (ROWS & (ROWS - 1)) != 0) begin : g_chk_rows
      $error("ROWS must be a power of two, at least 2");
   end
   if (BND_W < 8) begin : g_chk_bnd
      $error("BND_W must hold the 8-bit control byte");
   end
   if (ADDR_W < 25) begin : g_chk_addr
      $error("ADDR_W must cover the 16 MB hole limit");
   end
   if (UNIT_LOG2 < 1 || UNIT_LOG2 >= ADDR_W) begin : g_chk_unit
      $error("UNIT_LOG2 must lie inside the address");
   end

   logic [ROWS-1:0][BND_W-1:0] bnd;
   hole_sel_e                  hole_mode;

   rbd_cfg_regs #(.ROWS(ROWS), .BND_W(BND_W), .SEL_W(SEL_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (cfg_we),
      .sel    (cfg_sel),
      .wdata  (cfg_wdata),
      .bnd_o  (bnd),
      .hole_o (hole_mode)
   );

   logic [ROWS-1:0]  m_sel;
   logic [IDX_W-1:0] m_idx;
   logic             m_any;

   rbd_row_match #(.ROWS(ROWS), .BND_W(BND_W), .UW(UW), .IDX_W(IDX_W)) u_match (
      .bnd   (bnd),
      .units (addr[ADDR_W-1:UNIT_LOG2]),
      .sel   (m_sel),
      .idx   (m_idx),
      .any   (m_any)
   );

   logic h_in;

   rbd_hole_check #(.ADDR_W(ADDR_W)) u_hole (
      .mode    (hole_mode),
      .addr    (addr),
      .in_hole (h_in)
   );

   // hole gating of the match result
   logic             d_hit;
   logic [ROWS-1:0]  d_sel;
   logic [IDX_W-1:0] d_idx;

   assign d_hit = m_any & ~h_in;
   assign d_sel = d_hit ? m_sel : '0;
   assign d_idx = d_hit ? m_idx : '0;

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            row_select <= '0;
            row_index  <= '0;
            hit        <= 1'b0;
            in_hole    <= 1'b0;
         end else begin
            row_select <= d_sel;
            row_index  <= d_idx;
            hit        <= d_hit;
            in_hole    <= h_in;
         end
      end
   end else begin : g_out_comb
      assign row_select = d_sel;
      assign row_index  = d_idx;
      assign hit        = d_hit;
      assign in_hole    = h_in;
   end

   // ---------------- assertions ----------------
   assert_unprogrammed_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (bnd == '0) |-> !m_any)
      else $error("match with all boundaries zero");

   for (genvar g = 0; g < ROWS; g++) begin : g_empty_chk
      if (g == 0) begin : g_first
         assert_empty_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
            m_sel[0] |-> bnd[0] != '0)
            else $error("empty row 0 selected");
      end else begin : g_rest
         assert_empty_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
            m_sel[g] |-> bnd[g] != bnd[g-1])
            else $error("empty row %0d selected", g);
      end
   end

   assert_nohit_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (row_select == '0 && row_index == '0))
      else $error("select or index set without hit");

   assert_hole_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      in_hole |-> !hit)
      else $error("hit inside hole");

   assert_index_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> row_select[row_index])
      else $error("row_index disagrees with row_select");

   assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> $onehot(row_select))
      else $error("row_select not one-hot on hit");

endmodule

// File: tb/dram_row_decoder_tb.sv
module dram_row_decoder_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_sel = '0;
   logic [7:0]  cfg_wdata = '0;
   logic [31:0] addr = '0;
   logic [7:0]  row_select;
   logic [2:0]  row_index;
   logic        hit;
   logic        in_hole;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   dram_row_decoder u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_sel    (cfg_sel),
      .cfg_wdata  (cfg_wdata),
      .addr       (addr),
      .row_select (row_select),
      .row_index  (row_index),
      .hit        (hit),
      .in_hole    (in_hole)
   );

   // entry: [39:8] address, [4] hit, [3] in_hole, [2:0] row index
   // boundaries 2,4,4,8,9,9,9,16 and control byte 0x55 (low hole, junk reserved bits)
   localparam int NV = 17;
   localparam logic [39:0] VEC [NV] = '{
      {32'h0000_0000, 8'h10},   // R3 row 0 first byte
      {32'h0007_FFFF, 8'h10},   // R6 just under low hole
      {32'h0008_0000, 8'h08},   // R6 hole start
      {32'h0009_FFFF, 8'h08},   // R6 hole end
      {32'h000A_0000, 8'h10},   // R6 just past hole
      {32'h00F0_0000, 8'h10},   // R8 high window not enabled
      {32'h00FF_FFFF, 8'h10},   // R3 row 0 last byte
      {32'h0100_0000, 8'h11},   // R3 row 1 first byte
      {32'h01FF_FFFF, 8'h11},   // R3 row 1 last byte
      {32'h0200_0000, 8'h13},   // R4 row 2 empty, row 3 taken
      {32'h03FF_FFFF, 8'h13},   // R3 row 3 last byte
      {32'h0400_0000, 8'h14},   // R3 row 4 first byte
      {32'h047F_FFFF, 8'h14},   // R3 row 4 last byte
      {32'h0480_0000, 8'h17},   // R4 rows 5,6 empty, row 7 taken
      {32'h07FF_FFFF, 8'h17},   // R3 row 7 last byte
      {32'h0800_0000, 8'h00},   // R5 at top boundary
      {32'hFFFF_FFFF, 8'h00}    // R5 far above
   };

   task automatic chk_out(input string req, input logic eh, input logic eo, input logic [2:0] ei);
      logic [7:0]  es;
      logic [12:0] act, exp;
      es  = eh ? (8'b1 << ei) : 8'b0;
      act = {row_select, row_index, hit, in_hole};
      exp = {es, eh ? ei : 3'd0, eh, eo};
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s addr=%h sel/idx/hit/hole act=%b_%b_%b_%b exp=%b_%b_%b_%b",
                  req, addr, act[12:5], act[4:2], act[1], act[0],
                  exp[12:5], exp[4:2], exp[1], exp[0]);
      end
   endtask

   task automatic cfg_write(input logic [3:0] s, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic apply(input logic [31:0] a);
      @(negedge clk);
      addr = a;
      @(posedge clk);
      #1;
   endtask

   task automatic program_rows();
      cfg_write(4'd0, 8'd2);
      cfg_write(4'd1, 8'd4);
      cfg_write(4'd2, 8'd4);
      cfg_write(4'd3, 8'd8);
      cfg_write(4'd4, 8'd9);
      cfg_write(4'd5, 8'd9);
      cfg_write(4'd6, 8'd9);
      cfg_write(4'd7, 8'd16);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk_out("R1 outputs in reset", 1'b0, 1'b0, 3'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: unprogrammed boundaries give no hit
      apply(32'h0000_0000);
      chk_out("R1 unprogrammed addr 0", 1'b0, 1'b0, 3'd0);
      apply(32'h0123_4567);
      chk_out("R1 unprogrammed mid addr", 1'b0, 1'b0, 3'd0);

      program_rows();
      cfg_write(4'd8, 8'h55);

      // main table
      for (int i = 0; i < NV; i++) begin
         apply(VEC[i][39:8]);
         chk_out($sformatf("R3/R4/R5/R6 vector %0d", i), VEC[i][4], VEC[i][3], VEC[i][2:0]);
      end

      // R9: one-cycle output latency
      apply(32'h0100_0000);
      @(negedge clk);
      addr = 32'h0000_0000;
      #1;
      chk_out("R9 output holds before edge", 1'b1, 1'b0, 3'd1);
      @(posedge clk);
      #1;
      chk_out("R9 output after edge", 1'b1, 1'b0, 3'd0);

      // R7: high hole
      cfg_write(4'd8, 8'h80);
      apply(32'h00EF_FFFF); chk_out("R7 below high hole", 1'b1, 1'b0, 3'd0);
      apply(32'h00F0_0000); chk_out("R7 high hole start", 1'b0, 1'b1, 3'd0);
      apply(32'h00FF_FFFF); chk_out("R7 high hole end", 1'b0, 1'b1, 3'd0);
      apply(32'h0100_0000); chk_out("R7 past high hole", 1'b1, 1'b0, 3'd1);
      apply(32'h0008_0000); chk_out("R7 low window off", 1'b1, 1'b0, 3'd0);

      // R8: reserved code and no-hole code with reserved bits set
      cfg_write(4'd8, 8'hC0);
      apply(32'h0008_0000); chk_out("R8 code 11 low window", 1'b1, 1'b0, 3'd0);
      apply(32'h00F0_0000); chk_out("R8 code 11 high window", 1'b1, 1'b0, 3'd0);
      cfg_write(4'd8, 8'h3F);
      apply(32'h0009_FFFF); chk_out("R8 code 00 low window", 1'b1, 1'b0, 3'd0);
      apply(32'h00FF_FFFF); chk_out("R8 code 00 high window", 1'b1, 1'b0, 3'd0);

      // R2: out-of-range selects ignored
      cfg_write(4'd9, 8'h00);
      cfg_write(4'd15, 8'h40);
      cfg_write(4'd12, 8'hFF);
      apply(32'h0000_0000); chk_out("R2 ignored select row 0", 1'b1, 1'b0, 3'd0);
      apply(32'h0009_0000); chk_out("R2 ignored select hole", 1'b1, 1'b0, 3'd0);
      apply(32'h07FF_FFFF); chk_out("R2 ignored select top", 1'b1, 1'b0, 3'd7);
      apply(32'h0800_0000); chk_out("R2 ignored select above", 1'b0, 1'b0, 3'd0);

      // R2/R4: rewrite row 0 to zero; row 0 becomes empty
      cfg_write(4'd0, 8'd0);
      apply(32'h0000_0000); chk_out("R2 R4 row 0 emptied", 1'b1, 1'b0, 3'd1);
      cfg_write(4'd7, 8'd32);
      apply(32'h0800_0000); chk_out("R2 raised top boundary", 1'b1, 1'b0, 3'd7);
      apply(32'h0FFF_FFFF); chk_out("R5 new top last byte", 1'b1, 1'b0, 3'd7);
      apply(32'h1000_0000); chk_out("R5 new top boundary", 1'b0, 1'b0, 3'd0);

      // R1: reset mid-run clears outputs and registers
      apply(32'h0100_0000);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk_out("R1 async clear of outputs", 1'b0, 1'b0, 3'd0);
      @(negedge clk);
      rst_n = 1'b1;
      apply(32'h0100_0000); chk_out("R1 boundaries cleared", 1'b0, 1'b0, 3'd0);
      apply(32'h0008_0000); chk_out("R1 hole cleared", 1'b0, 1'b0, 3'd0);

      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule